// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the line and frame timing for a TFT-style LCD panel. Each pixel-clock enable pulse from an outside divider moves it one step through the raster. Every line has five segments in a fixed order. The first is a delay between the start of the line and HSYNC, then the HSYNC pulse, then a back porch, then the active pixels, then a front porch. Every frame has four segments in a fixed order: the VSYNC lines, the vertical back porch, the active lines and the vertical front porch. Each segment length is programmable as "count minus one". As a result, a line lasts the sum of its five fields plus five pixel clocks.

The outputs are HSYNC, VSYNC, a data-enable strobe, a qualifier that marks pixel-clock ticks carrying active data, and a line counter. The line counter is reloaded with the active line field when a frame starts. It then counts down by one on each HSYNC falling edge. The front porch field is the intended knob for trimming the frame rate once the other fields are set. All fields are taken in only at frame boundaries, so a change made during a frame is applied cleanly to the next one. For a colour panel the active field is three times the pixel count minus one. For a monochrome panel it is the pixel count minus one.

Top module: `lcd_raster_timer`

## Requirements
- R1: While reset is held low, and after its release before any pixel tick, VSYNC is high, HSYNC is low, data enable is low, and the line counter equals the active line field.
- R2: The timing advances only on clock edges where `pix_ce` is high. A line lasts delay + hpulse + hback + hactive + hfront + 5 ticks.
- R3: Counting ticks from 0 at line start, HSYNC is high from tick delay+1 for exactly hpulse+1 ticks.
- R4: Counting lines from 0 at frame start, VSYNC is high on lines 0 to vpulse for the whole of each line. A frame lasts vpulse + vback + vactive + vfront + 4 lines.
- R5: Data enable is high only when both conditions hold. The tick must lie in the hactive+1 ticks that start at tick delay+hpulse+hback+3. The line must lie in the vactive+1 lines that start at line vpulse+vback+2.
- R6: `pix_qual_o` equals `pix_ce` ANDed with data enable.
- R7: On the clock edge where HSYNC falls, the line counter decreases by exactly one, wrapping modulo 2^VW.
- R8: On the clock edge that starts a new frame, the line counter loads the active line field of the new frame.
- R9: All nine timing fields are sampled at reset and on each frame start. Changes between those points leave the current frame's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_ce | input | 1 | Pixel-clock enable from the external divider |
| cfg_hs_delay | input | HW | Ticks from line start to HSYNC, minus one |
| cfg_hs_width | input | HW | HSYNC width in ticks, minus one |
| cfg_h_back | input | HW | Horizontal back porch in ticks, minus one |
| cfg_h_active | input | HW | Active width in ticks, minus one |
| cfg_h_front | input | HW | Horizontal front porch in ticks, minus one |
| cfg_vs_width | input | VW | VSYNC width in lines, minus one |
| cfg_v_back | input | VW | Vertical back porch in lines, minus one |
| cfg_v_active | input | VW | Active line count, minus one |
| cfg_v_front | input | VW | Vertical front porch in lines, minus one |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| pix_qual_o | output | 1 | Pixel-clock enable restricted to active data |
| line_cnt_o | output | VW | Down-counting line counter |

## Verification
The assertions assume that `pix_ce` is a clean single-cycle-wide qualifier. They also assume the configuration ports are steady at least across each frame-start edge, so that the value taken in is well defined. The bench always drives inputs on the falling clock edge. It changes fields only through a staging step at that edge. It mixes continuous and irregular `pix_ce` patterns, so every segment boundary is reached both with and without idle cycles around it. Field changes are made in mid-frame. They include all-zero fields, which give one-tick segments, and an active line count small enough that the counter wraps below zero.

// File: rtl/lrt_pkg.sv
// Shared phase encodings and phase-order helpers for the raster timer.
// Assumes: phases run strictly in the order listed; each phase is at least one tick/line.
package lrt_pkg;

    typedef enum logic [2:0] {
        H_DLY,
        H_SYNC,
        H_BACK,
        H_ACT,
        H_FRONT
    } h_phase_t;

    typedef enum logic [1:0] {
        V_SYNC,
        V_BACK,
        V_ACT,
        V_FRONT
    } v_phase_t;

    // Horizontal phase that follows p within a line.
    function automatic h_phase_t h_after(h_phase_t p);
        case (p)
            H_DLY:   return H_SYNC;
            H_SYNC:  return H_BACK;
            H_BACK:  return H_ACT;
            H_ACT:   return H_FRONT;
            default: return H_DLY;
        endcase
    endfunction

    // Vertical phase that follows p within a frame.
    function automatic v_phase_t v_after(v_phase_t p);
        case (p)
            V_SYNC:  return V_BACK;
            V_BACK:  return V_ACT;
            V_ACT:   return V_FRONT;
            default: return V_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lrt_cfg_hold.sv
// Holds one bundle of timing fields for the duration of a frame.
// Loads the live inputs while reset is low and on each frame-start event.
// The "use" output already shows the incoming value in the loading cycle, so
// sequencers that reload on that same edge pick up the new frame's fields.
module lrt_cfg_hold #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] d,
    output logic [W-1:0] use_o
);
    logic [W-1:0] q;
    logic         load;

    assign load  = !rst_n || take;
    assign use_o = load ? d : q;

    // Capture fields at reset and at frame start only.
    always_ff @(posedge clk) begin
        if (load) q <= d;
    end

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(q));

endmodule

// File: rtl/lrt_hseq.sv
// Horizontal sequencer: walks delay, sync, back porch, active, front porch.
// Each phase lasts (field + 1) pixel ticks, timed by a down counter.
// Assumes the field inputs are the frame's effective values (see lrt_cfg_hold).
module lrt_hseq
    import lrt_pkg::*;
#(
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_ce,
    input  logic [HW-1:0] f_dly,
    input  logic [HW-1:0] f_sync,
    input  logic [HW-1:0] f_back,
    input  logic [HW-1:0] f_act,
    input  logic [HW-1:0] f_front,
    output logic          hsync,
    output logic          h_active,
    output logic          line_end,
    output logic          sync_end
);
    h_phase_t      ph, ph_nxt;
    logic [HW-1:0] cnt, len_nxt;

    // Pick the next phase and its tick length.
    always_comb begin
        ph_nxt = h_after(ph);
        case (ph_nxt)
            H_DLY:   len_nxt = f_dly;
            H_SYNC:  len_nxt = f_sync;
            H_BACK:  len_nxt = f_back;
            H_ACT:   len_nxt = f_act;
            default: len_nxt = f_front;
        endcase
    end

    // Step the phase counter on each pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= H_DLY;
            cnt <= f_dly;
        end else if (pix_ce) begin
            if (cnt == '0) begin
                ph  <= ph_nxt;
                cnt <= len_nxt;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign hsync    = (ph == H_SYNC);
    assign h_active = (ph == H_ACT);
    assign line_end = (ph == H_FRONT) && (cnt == '0);
    assign sync_end = (ph == H_SYNC)  && (cnt == '0);

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> $stable(ph) && $stable(cnt));

endmodule

// File: rtl/lrt_vseq.sv
// Vertical sequencer: walks sync lines, back porch, active lines, front porch.
// Each phase lasts (field + 1) lines; it advances once per completed line.
module lrt_vseq
    import lrt_pkg::*;
#(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [VW-1:0] f_sync,
    input  logic [VW-1:0] f_back,
    input  logic [VW-1:0] f_act,
    input  logic [VW-1:0] f_front,
    output logic          vsync,
    output logic          v_active,
    output logic          frame_last
);
    v_phase_t      ph, ph_nxt;
    logic [VW-1:0] cnt, len_nxt;

    // Pick the next vertical phase and its line length.
    always_comb begin
        ph_nxt = v_after(ph);
        case (ph_nxt)
            V_SYNC:  len_nxt = f_sync;
            V_BACK:  len_nxt = f_back;
            V_ACT:   len_nxt = f_act;
            default: len_nxt = f_front;
        endcase
    end

    // Step the line counter at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= V_SYNC;
            cnt <= f_sync;
        end else if (adv) begin
            if (cnt == '0) begin
                ph  <= ph_nxt;
                cnt <= len_nxt;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign vsync      = (ph == V_SYNC);
    assign v_active   = (ph == V_ACT);
    assign frame_last = (ph == V_FRONT) && (cnt == '0);

    assert_vsync_whole_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(vsync));

endmodule

// File: rtl/lrt_line_count.sv
// Down-counting line counter: reloads at frame start, steps down by one on
// the edge where HSYNC ends. Wraps modulo 2^VW.
module lrt_line_count #(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec,
    input  logic          reload,
    input  logic [VW-1:0] reload_val,
    output logic [VW-1:0] cnt
);
    // Reload on frame start, otherwise decrement on HSYNC end.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) cnt <= reload_val;
        else if (dec)         cnt <= cnt - 1'b1;
    end

    assert_reload_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt == $past(reload_val));

endmodule

// File: rtl/lcd_raster_timer.sv
// Top of the LCD raster timing generator.
// Combines the field holders, the horizontal and vertical sequencers and the
// line counter. Assumes pix_ce is a one-clock enable from an external divider.
module lcd_raster_timer #(
    parameter int HW = 10,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_ce,
    input  logic [HW-1:0] cfg_hs_delay,
    input  logic [HW-1:0] cfg_hs_width,
    input  logic [HW-1:0] cfg_h_back,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [HW-1:0] cfg_h_front,
    input  logic [VW-1:0] cfg_vs_width,
    input  logic [VW-1:0] cfg_v_back,
    input  logic [VW-1:0] cfg_v_active,
    input  logic [VW-1:0] cfg_v_front,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pix_qual_o,
    output logic [VW-1:0] line_cnt_o
);
    localparam int HBUS = 5 * HW;
    localparam int VBUS = 4 * VW;

    logic [HBUS-1:0] h_in, h_use;
    logic [VBUS-1:0] v_in, v_use;
    logic            h_active, v_active, line_end, sync_end, frame_last;
    logic            line_adv, frame_evt;

    assign h_in = {cfg_hs_delay, cfg_hs_width, cfg_h_back, cfg_h_active, cfg_h_front};
    assign v_in = {cfg_vs_width, cfg_v_back, cfg_v_active, cfg_v_front};

    assign line_adv  = pix_ce && line_end;
    assign frame_evt = line_adv && frame_last;

    lrt_cfg_hold #(.W(HBUS)) u_hcfg (
        .clk(clk), .rst_n(rst_n), .take(frame_evt), .d(h_in), .use_o(h_use)
    );

    lrt_cfg_hold #(.W(VBUS)) u_vcfg (
        .clk(clk), .rst_n(rst_n), .take(frame_evt), .d(v_in), .use_o(v_use)
    );

    lrt_hseq #(.HW(HW)) u_hseq (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
        .f_dly  (h_use[4*HW +: HW]),
        .f_sync (h_use[3*HW +: HW]),
        .f_back (h_use[2*HW +: HW]),
        .f_act  (h_use[1*HW +: HW]),
        .f_front(h_use[0    +: HW]),
        .hsync(hsync_o), .h_active(h_active),
        .line_end(line_end), .sync_end(sync_end)
    );

    lrt_vseq #(.VW(VW)) u_vseq (
        .clk(clk), .rst_n(rst_n), .adv(line_adv),
        .f_sync (v_use[3*VW +: VW]),
        .f_back (v_use[2*VW +: VW]),
        .f_act  (v_use[1*VW +: VW]),
        .f_front(v_use[0    +: VW]),
        .vsync(vsync_o), .v_active(v_active), .frame_last(frame_last)
    );

    lrt_line_count #(.VW(VW)) u_lcnt (
        .clk(clk), .rst_n(rst_n),
        .dec(pix_ce && sync_end), .reload(frame_evt),
        .reload_val(v_use[1*VW +: VW]),
        .cnt(line_cnt_o)
    );

    assign de_o       = h_active && v_active;
    assign pix_qual_o = pix_ce && de_o;

    assert_hsync_fall_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_o) |-> line_cnt_o == $past(line_cnt_o) - 1'b1);

    assert_de_outside_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !hsync_o && !vsync_o);

    assert_frame_start_vsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> vsync_o);

endmodule

// File: tb/lcd_raster_timer_tb.sv
`timescale 1ns/1ps
module lcd_raster_timer_tb;
    localparam int HW = 10;
    localparam int VW = 10;
    localparam int VMASK = (1 << VW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_ce = 1'b0;
    logic [HW-1:0] cfg_hs_delay, cfg_hs_width, cfg_h_back, cfg_h_active, cfg_h_front;
    logic [VW-1:0] cfg_vs_width, cfg_v_back, cfg_v_active, cfg_v_front;
    logic          hsync_o, vsync_o, de_o, pix_qual_o;
    logic [VW-1:0] line_cnt_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Staged fields: dly, hpw, hbp, hact, hfp, vpw, vbp, vact, vfp
    int nxt[9];
    // Model state: latched fields, tick within line, line within frame
    int c[9];
    int m_hpos, m_vline, m_lcnt, m_ce;

    always #5 clk = ~clk;

    lcd_raster_timer #(.HW(HW), .VW(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
        .cfg_hs_delay(cfg_hs_delay), .cfg_hs_width(cfg_hs_width),
        .cfg_h_back(cfg_h_back), .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front),
        .cfg_vs_width(cfg_vs_width), .cfg_v_back(cfg_v_back),
        .cfg_v_active(cfg_v_active), .cfg_v_front(cfg_v_front),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pix_qual_o(pix_qual_o), .line_cnt_o(line_cnt_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply_cfg();
        cfg_hs_delay = HW'(nxt[0]); cfg_hs_width = HW'(nxt[1]);
        cfg_h_back   = HW'(nxt[2]); cfg_h_active = HW'(nxt[3]);
        cfg_h_front  = HW'(nxt[4]);
        cfg_vs_width = VW'(nxt[5]); cfg_v_back   = VW'(nxt[6]);
        cfg_v_active = VW'(nxt[7]); cfg_v_front  = VW'(nxt[8]);
    endtask

    task automatic stage(input int a0, a1, a2, a3, a4, a5, a6, a7, a8);
        nxt = '{a0, a1, a2, a3, a4, a5, a6, a7, a8};
    endtask

    task automatic model_latch();
        for (int i = 0; i < 9; i++) c[i] = nxt[i];
    endtask

    // Expected outputs from the model's position (R2..R8)
    task automatic compare();
        int hs_lo, ha_lo, va_lo;
        bit e_hs, e_vs, e_de;
        hs_lo = c[0] + 1;
        ha_lo = c[0] + c[1] + c[2] + 3;
        va_lo = c[5] + c[6] + 2;
        e_hs = (m_hpos >= hs_lo) && (m_hpos < hs_lo + c[1] + 1);
        e_vs = (m_vline <= c[5]);
        e_de = (m_hpos >= ha_lo) && (m_hpos < ha_lo + c[3] + 1) &&
               (m_vline >= va_lo) && (m_vline < va_lo + c[7] + 1);
        chk(int'(hsync_o), int'(e_hs), "R2/R3 hsync");
        chk(int'(vsync_o), int'(e_vs), "R4/R9 vsync");
        chk(int'(de_o), int'(e_de), "R5 de");
        chk(int'(pix_qual_o), int'(e_de) & m_ce, "R6 pix_qual");
        chk(int'(line_cnt_o), m_lcnt, "R7/R8 line_cnt");
    endtask

    // Advance the model by one pixel tick (fields latched only at frame start: R9)
    task automatic model_step();
        int len_l, len_f;
        len_l = c[0] + c[1] + c[2] + c[3] + c[4] + 5;
        len_f = c[5] + c[6] + c[7] + c[8] + 4;
        if (m_hpos == c[0] + c[1] + 1) m_lcnt = (m_lcnt - 1) & VMASK;
        m_hpos++;
        if (m_hpos == len_l) begin
            m_hpos = 0;
            m_vline++;
            if (m_vline == len_f) begin
                m_vline = 0;
                model_latch();
                m_lcnt = c[7];
            end
        end
    endtask

    task automatic tick(input bit ce);
        @(negedge clk);
        compare();
        apply_cfg();
        pix_ce = ce;
        m_ce = int'(ce);
        if (ce) model_step();
    endtask

    initial begin
        stage(1, 2, 1, 7, 2, 0, 1, 3, 1);
        apply_cfg();
        repeat (3) @(negedge clk);
        // R1: values while reset is still low
        chk(int'(vsync_o), 1, "R1 vsync in reset");
        chk(int'(hsync_o), 0, "R1 hsync in reset");
        chk(int'(de_o), 0, "R1 de in reset");
        chk(int'(line_cnt_o), 3, "R1 line_cnt in reset");
        rst_n = 1'b1;
        model_latch();
        m_hpos = 0; m_vline = 0; m_lcnt = c[7]; m_ce = 0;
        @(negedge clk);
        // R1: after release, before any tick
        chk(int'(vsync_o), 1, "R1 vsync after release");
        chk(int'(hsync_o), 0, "R1 hsync after release");
        chk(int'(line_cnt_o), 3, "R1 line_cnt after release");
        // Continuous ticks, several frames, counter wraps below zero (R7)
        for (int i = 0; i < 600; i++) tick(1'b1);
        // Irregular ticks; mid-frame field changes must wait for frame start (R9)
        for (int i = 0; i < 1500; i++) begin
            if (i == 700)  stage(0, 0, 0, 0, 0, 0, 0, 0, 0);
            if (i == 1200) stage(0, 0, 3, 15, 0, 2, 0, 1, 0);
            tick(($urandom % 3) != 0);
        end
        // Continuous again, back to the first field set
        for (int i = 0; i < 1500; i++) begin
            if (i == 333) stage(1, 2, 1, 7, 2, 0, 1, 3, 1);
            tick(1'b1);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule